// File: doc/BRIEF.md
# Low-Power Mode Selection Controller

This block tracks which power mode a small microcontroller core is in. It drives the clock-enable and regulator-control outputs that match that mode. It samples a set of configuration bits: debug enable, voltage-monitor enable, voltage-monitor-active-in-stop, low-power-run request, partial-power-down select and stop enable. It also samples one-cycle WAIT and STOP strobes from the CPU and a wake input. The clock generator, the regulator analog, the flash and the real-time clock are outside the block; they consume its outputs.

The controller has six states. `ST_RUN` is normal run. `ST_LPRUN` is low-power run. `ST_WAIT` and `ST_LPWAIT` are the two wait states. `ST_SSTOP` is shallow stop and `ST_DSTOP` is deep stop with partial power-down.

The transitions are these:
- enter-lprun: from `ST_RUN` to `ST_LPRUN`.
- leave-lprun: from `ST_LPRUN` to `ST_RUN`.
- wait-entry: from either run state into its wait state.
- wait-wake: from a wait state back to the run state it came from.
- stop-entry: from either run state into `ST_SSTOP` or `ST_DSTOP`.
- stop-wake: from either stop state to `ST_RUN`.
- illegal-stop: a self-loop in a run state.

Every output is a register. Its value is decoded from the state being entered and from the current configuration.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst` is high, the next clock edge sets the following values: `mode_code`=0, `cpu_clk_en`=1, `per_clk_en`=1, `per_low_speed`=0, `dbg_clk_en`=0, `reg_state`=0, `deep_wake`=0 and `illegal_stop`=0.
- R2: In normal run (`mode_code`=0) the CPU and peripheral clocks are on, `per_low_speed`=0 and `reg_state`=0 (on). In every state except deep stop, `dbg_clk_en` equals `dbg_en`.
- R3: Normal run enters low-power run (`mode_code`=1) only when `lprun_req`=1, `dbg_en`=0 and `mon_en`=0. In low-power run the clocks stay on, `per_low_speed`=1 and `reg_state`=1 (standby). Clearing `lprun_req` returns the block to normal run at the next edge.
- R4: A WAIT strobe in normal run enters wait (`mode_code`=2). In wait, `cpu_clk_en`=0, `per_clk_en`=1, `per_low_speed`=0 and `reg_state`=0. A wake returns the block to normal run.
- R5: A WAIT strobe in low-power run enters low-power wait (`mode_code`=3). In low-power wait, `cpu_clk_en`=0, `per_clk_en`=1, `per_low_speed`=1 and `reg_state`=1. A wake returns the block to low-power run.
- R6: A STOP strobe in a run state with `stop_en`=0 leaves the mode unchanged and raises `illegal_stop` for exactly one cycle.
- R7: A STOP strobe with `stop_en`=1, `ppd_sel`=1, `dbg_en`=0 and `mon_en`=0 enters deep stop (`mode_code`=5). In deep stop all clock enables are 0 and `reg_state`=2 (partial power-down).
- R8: When `dbg_en` or `mon_en` is set, an enabled STOP enters shallow stop (`mode_code`=4) even with `ppd_sel`=1. The same happens when `ppd_sel`=0. In shallow stop the CPU and peripheral clocks are off.
- R9: In shallow stop, `reg_state` is 0 when `dbg_en`=1 or when both `mon_en` and `mon_stop_en` are 1; otherwise it is 1. It follows configuration changes made during stop one edge later.
- R10: A wake in either stop state returns the block to normal run. Leaving deep stop also raises `deep_wake` for exactly one cycle.
- R11: A STOP strobe takes priority over a WAIT strobe in the same cycle. Both strobes are ignored in wait and stop states.
- R12: Every output changes at the clock edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_en | input | 1 | Debug enable |
| mon_en | input | 1 | Voltage monitor enable |
| mon_stop_en | input | 1 | Voltage monitor active during stop |
| lprun_req | input | 1 | Low-power run request |
| ppd_sel | input | 1 | Partial power-down select for stop |
| stop_en | input | 1 | Stop instruction enable |
| wait_stb | input | 1 | One-cycle WAIT instruction strobe |
| stop_stb | input | 1 | One-cycle STOP instruction strobe |
| wake | input | 1 | Wake / interrupt request |
| mode_code | output | 3 | Current mode: 0 run, 1 lp run, 2 wait, 3 lp wait, 4 shallow stop, 5 deep stop |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_low_speed | output | 1 | Peripheral clocks at low speed |
| dbg_clk_en | output | 1 | Debug clock enable |
| reg_state | output | 2 | Regulator code: 0 on, 1 standby, 2 partial power-down |
| deep_wake | output | 1 | One-cycle flag on wake from deep stop |
| illegal_stop | output | 1 | One-cycle flag for a STOP strobe while stop is disabled |

## Verification
The outputs are decoded from the state being entered, so a wrong state shows on `mode_code` and the clock and regulator outputs at the same edge. A bad stop-selection decision shows up within one cycle of the STOP strobe. A wait state that records the wrong run state to return to stays hidden until the wake, and then shows up as the wrong `mode_code` and `per_low_speed` one edge later. A lost `deep_wake` or `illegal_stop` pulse is caught because the bench compares every output on every cycle.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
    localparam int MODE_W = 3;
    localparam int REG_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        ST_RUN    = 3'd0,
        ST_LPRUN  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_LPWAIT = 3'd3,
        ST_SSTOP  = 3'd4,
        ST_DSTOP  = 3'd5
    } pm_state_e;

    typedef enum logic [REG_W-1:0] {
        REG_ON   = 2'd0,
        REG_STBY = 2'd1,
        REG_PPD  = 2'd2
    } reg_code_e;

    typedef struct packed {
        logic      cpu;
        logic      per;
        logic      low;
        logic      dbg;
        reg_code_e regc;
    } pm_out_t;
endpackage

// File: rtl/pmode_next.sv
module pmode_next
    import pmode_pkg::*;
(
    input  pm_state_e state,
    input  logic      dbg_en,
    input  logic      mon_en,
    input  logic      lprun_req,
    input  logic      ppd_sel,
    input  logic      stop_en,
    input  logic      wait_stb,
    input  logic      stop_stb,
    input  logic      wake,
    output pm_state_e nxt,
    output logic      illegal,
    output logic      dwake
);
    logic quiet;      // no debug, no monitor
    pm_state_e stop_tgt;

    assign quiet    = !dbg_en && !mon_en;
    assign stop_tgt = (ppd_sel && quiet) ? ST_DSTOP : ST_SSTOP;

    always_comb begin
        nxt     = state;
        illegal = 1'b0;
        dwake   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (stop_stb) begin
                    if (stop_en) nxt = stop_tgt;
                    else         illegal = 1'b1;
                end else if (wait_stb) begin
                    nxt = ST_WAIT;
                end else if (lprun_req && quiet) begin
                    nxt = ST_LPRUN;
                end
            end
            ST_LPRUN: begin
                if (stop_stb) begin
                    if (stop_en) nxt = stop_tgt;
                    else         illegal = 1'b1;
                end else if (wait_stb) begin
                    nxt = ST_LPWAIT;
                end else if (!lprun_req) begin
                    nxt = ST_RUN;
                end
            end
            ST_WAIT:   if (wake) nxt = ST_RUN;
            ST_LPWAIT: if (wake) nxt = ST_LPRUN;
            ST_SSTOP:  if (wake) nxt = ST_RUN;
            ST_DSTOP: begin
                if (wake) begin
                    nxt   = ST_RUN;
                    dwake = 1'b1;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end
endmodule

// File: rtl/pmode_outdec.sv
module pmode_outdec
    import pmode_pkg::*;
(
    input  pm_state_e state,
    input  logic      dbg_en,
    input  logic      mon_en,
    input  logic      mon_stop_en,
    output pm_out_t   o
);
    logic stop_keep_on;

    assign stop_keep_on = dbg_en || (mon_en && mon_stop_en);

    always_comb begin
        o = '{cpu: 1'b1, per: 1'b1, low: 1'b0, dbg: dbg_en, regc: REG_ON};
        unique case (state)
            ST_RUN: ;
            ST_LPRUN: begin
                o.low  = 1'b1;
                o.regc = REG_STBY;
            end
            ST_WAIT: o.cpu = 1'b0;
            ST_LPWAIT: begin
                o.cpu  = 1'b0;
                o.low  = 1'b1;
                o.regc = REG_STBY;
            end
            ST_SSTOP: begin
                o.cpu  = 1'b0;
                o.per  = 1'b0;
                o.regc = stop_keep_on ? REG_ON : REG_STBY;
            end
            ST_DSTOP: begin
                o.cpu  = 1'b0;
                o.per  = 1'b0;
                o.dbg  = 1'b0;
                o.regc = REG_PPD;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_en,
    input  logic              mon_en,
    input  logic              mon_stop_en,
    input  logic              lprun_req,
    input  logic              ppd_sel,
    input  logic              stop_en,
    input  logic              wait_stb,
    input  logic              stop_stb,
    input  logic              wake,
    output logic [MODE_W-1:0] mode_code,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              per_low_speed,
    output logic              dbg_clk_en,
    output logic [REG_W-1:0]  reg_state,
    output logic              deep_wake,
    output logic              illegal_stop
);
    pm_state_e state_q, state_d;
    logic      illegal_d, dwake_d;
    pm_out_t   dec;

    pmode_next u_next (
        .state(state_q), .dbg_en(dbg_en), .mon_en(mon_en),
        .lprun_req(lprun_req), .ppd_sel(ppd_sel), .stop_en(stop_en),
        .wait_stb(wait_stb), .stop_stb(stop_stb), .wake(wake),
        .nxt(state_d), .illegal(illegal_d), .dwake(dwake_d)
    );

    pmode_outdec u_dec (
        .state(state_d), .dbg_en(dbg_en), .mon_en(mon_en),
        .mon_stop_en(mon_stop_en), .o(dec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_clk_en    <= 1'b1;
            per_clk_en    <= 1'b1;
            per_low_speed <= 1'b0;
            dbg_clk_en    <= 1'b0;
            reg_state     <= REG_ON;
            deep_wake     <= 1'b0;
            illegal_stop  <= 1'b0;
        end else begin
            cpu_clk_en    <= dec.cpu;
            per_clk_en    <= dec.per;
            per_low_speed <= dec.low;
            dbg_clk_en    <= dec.dbg;
            reg_state     <= dec.regc;
            deep_wake     <= dwake_d;
            illegal_stop  <= illegal_d;
        end
    end

    assign mode_code = state_q;

    logic in_run;
    assign in_run = (state_q == ST_RUN) || (state_q == ST_LPRUN);

    assert_illegal_hold_R6: assert property (@(posedge clk) disable iff (rst)
        in_run && stop_stb && !stop_en |=> illegal_stop && mode_code == $past(mode_code));

    assert_shallow_forced_R8: assert property (@(posedge clk) disable iff (rst)
        in_run && stop_stb && stop_en && (dbg_en || mon_en) |=> mode_code == 3'd4);

    assert_deep_wake_R10: assert property (@(posedge clk) disable iff (rst)
        deep_wake |-> mode_code == 3'd0 && $past(mode_code) == 3'd5);

    assert_ppd_outputs_R7: assert property (@(posedge clk) disable iff (rst)
        mode_code == 3'd5 |-> reg_state == 2'd2 && !cpu_clk_en && !per_clk_en && !dbg_clk_en);

    assert_wait_cpu_off_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd2 || mode_code == 3'd3) |-> !cpu_clk_en && per_clk_en);

    assert_strobes_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT || state_q == ST_LPWAIT) && !wake |=> $stable(mode_code));
endmodule

// File: tb/test_pmode_ctrl.sv
`timescale 1ns/1ps
module test_pmode_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dbg, mon, mons, lpr, ppd, sen, ws, ss, wk;
    logic [2:0] mode_code;
    logic cpu, per, low, dclk, dw, il;
    logic [1:0] regs;

    always #2 clk = ~clk;   // 250 MHz

    pmode_ctrl i_pmode_ctrl (
        .clk(clk), .rst(rst), .dbg_en(dbg), .mon_en(mon), .mon_stop_en(mons),
        .lprun_req(lpr), .ppd_sel(ppd), .stop_en(sen), .wait_stb(ws),
        .stop_stb(ss), .wake(wk), .mode_code(mode_code), .cpu_clk_en(cpu),
        .per_clk_en(per), .per_low_speed(low), .dbg_clk_en(dclk),
        .reg_state(regs), .deep_wake(dw), .illegal_stop(il)
    );

    typedef struct {
        logic [2:0] m;
        logic [5:0] flags;   // cpu per low dbg dw il
        logic [1:0] r;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // driver: push expectation for the coming edge, then advance
    task automatic tick(input logic [2:0] m, input logic c, p, l, d,
                        input logic [1:0] r, input logic dwe, ile, input string tag);
        exp_t e;
        e.m = m; e.flags = {c, p, l, d, dwe, ile}; e.r = r; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        ws = 0; ss = 0; wk = 0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [5:0] act;
                e = q.pop_front();
                act = {cpu, per, low, dclk, dw, il};
                n_run++;
                if (mode_code !== e.m || act !== e.flags || regs !== e.r) begin
                    n_fail++;
                    $display("FAIL %s: actual mode=%0d flags=%b reg=%0d expected mode=%0d flags=%b reg=%0d",
                             e.tag, mode_code, act, regs, e.m, e.flags, e.r);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        {dbg, mon, mons, lpr, ppd, sen, ws, ss, wk} = '0;
        @(negedge clk);
        // R1 reset
        tick(0, 1,1,0,0, 0, 0,0, "R1 reset");
        tick(0, 1,1,0,0, 0, 0,0, "R1 reset hold");
        rst = 0;
        tick(0, 1,1,0,0, 0, 0,0, "R2 run");
        dbg = 1;
        tick(0, 1,1,0,1, 0, 0,0, "R2 run dbg clock");
        dbg = 0; lpr = 1; mon = 1;
        tick(0, 1,1,0,0, 0, 0,0, "R3 lprun blocked by monitor");
        mon = 0;
        tick(1, 1,1,1,0, 1, 0,0, "R3 lprun entry");
        ws = 1;
        tick(3, 0,1,1,0, 1, 0,0, "R5 lpwait entry");
        tick(3, 0,1,1,0, 1, 0,0, "R5 lpwait hold");
        sen = 1; ss = 1; ws = 1;
        tick(3, 0,1,1,0, 1, 0,0, "R11 strobes ignored in lpwait");
        wk = 1;
        tick(1, 1,1,1,0, 1, 0,0, "R5 wake to lprun");
        lpr = 0;
        tick(0, 1,1,0,0, 0, 0,0, "R3 leave lprun");
        ws = 1;
        tick(2, 0,1,0,0, 0, 0,0, "R4 wait entry");
        wk = 1;
        tick(0, 1,1,0,0, 0, 0,0, "R4 wake to run");
        sen = 0; ss = 1;
        tick(0, 1,1,0,0, 0, 0,1, "R6 illegal stop");
        tick(0, 1,1,0,0, 0, 0,0, "R6 illegal pulse one cycle");
        sen = 1; ppd = 1; ss = 1; ws = 1;
        tick(5, 0,0,0,0, 2, 0,0, "R7 R11 deep stop over wait");
        tick(5, 0,0,0,0, 2, 0,0, "R7 deep stop hold");
        wk = 1;
        tick(0, 1,1,0,0, 0, 1,0, "R10 deep wake flag");
        tick(0, 1,1,0,0, 0, 0,0, "R10 deep wake one cycle");
        dbg = 1; ss = 1;
        tick(4, 0,0,0,1, 0, 0,0, "R8 R9 shallow with debug");
        wk = 1;
        tick(0, 1,1,0,1, 0, 0,0, "R10 shallow wake");
        dbg = 0; mon = 1; mons = 1; ss = 1;
        tick(4, 0,0,0,0, 0, 0,0, "R8 R9 shallow monitor in stop");
        mons = 0;
        tick(4, 0,0,0,0, 1, 0,0, "R9 config change in stop");
        wk = 1;
        tick(0, 1,1,0,0, 0, 0,0, "R10 shallow wake 2");
        mon = 0; ppd = 0; ss = 1;
        tick(4, 0,0,0,0, 1, 0,0, "R8 R9 shallow no ppd");
        wk = 1;
        tick(0, 1,1,0,0, 0, 0,0, "R10 shallow wake 3");
        lpr = 1;
        tick(1, 1,1,1,0, 1, 0,0, "R3 lprun again");
        sen = 0; ss = 1;
        tick(1, 1,1,1,0, 1, 0,1, "R6 illegal in lprun");
        sen = 1; ppd = 1; ss = 1;
        tick(5, 0,0,0,0, 2, 0,0, "R7 deep stop from lprun");
        wk = 1;
        tick(0, 1,1,0,0, 0, 1,0, "R10 deep wake from lprun");
        tick(1, 1,1,1,0, 1, 0,0, "R3 R12 reenter lprun");
        lpr = 0;
        tick(0, 1,1,0,0, 0, 0,0, "R3 R12 exit lprun");
        @(posedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule